// File: doc/BRIEF.md
# Hashed MAC Learning Table

This block is the forwarding-address store of a multi-port Ethernet switch. Every arriving frame presents its destination and source MAC addresses together with the VLAN ID and the ingress port. One cycle later the block returns whether the destination is known and, if so, the port it lives on, whether the entry is static, and whether the port field is a pointer into an output port map rather than a port number. The source address is looked up at the same time. A known source has its age cleared. An unknown source is held as a learning candidate until the frame's end-of-frame status arrives, and it is written only if the frame turned out clean.

Entries are keyed by MAC plus VID. The key is folded by XOR into a set index, and each set holds several ways, so one MAC can live under several VIDs at once. A management port can create, overwrite or delete any entry and can mark it static. A periodic aging tick, issued every 300 ms by the surrounding chip, starts a sweep that walks all sets one per cycle. The sweep advances the age of dynamic entries and removes an entry whose age would pass its maximum.

Top module: `mac_learn_table`

## Requirements
- R1: After reset the table is empty: every lookup misses and `res_valid` is low until the first lookup.
- R2: A lookup accepted on a clock edge (`lk_valid` high) gives `res_valid` high after that edge, for one cycle per lookup. `res_hit` tells whether an entry with key (`lk_da`, `lk_vid`) exists, and `res_port`, `res_static` and `res_ptr` carry that entry's fields. On a miss these three outputs are zero.
- R3: The set index is the XOR fold of the key {VID, MAC}: key bit i is XORed into index bit (i mod IDX_W). Entries with the same MAC and different VIDs coexist and resolve independently.
- R4: When the source key of a lookup is in the table, that entry's age returns to zero.
- R5: An unknown source is learned, with its ingress port, non-static and with no pointer flag, only at the end-of-frame strobe that follows its lookup, and only if `eof_good` is high and `eof_pause` and `eof_secviol` are both low.
- R6: No learning happens for a source MAC whose group bit (bit MAC_W-8, the lowest bit of the first octet) is 1. It also does not happen when the ingress port's `port_block` bit or `port_learn_off` bit was set at lookup time.
- R7: A new entry goes to the lowest-numbered invalid way of its set. If all ways are valid, it replaces the non-static way with the greatest age, and the lowest way wins a tie. If every way is static, nothing is written.
- R8: An `age_tick` pulse, when no sweep is running, starts a sweep. The sweep adds one to the age of each valid non-static entry and invalidates an entry whose age is already at its maximum (3 with AGE_W=2). A dynamic entry therefore survives three sweeps after its last learn or refresh and is gone after the fourth. Static entries are never aged.
- R9: While `age_dis` is high, `age_tick` starts no sweep and ages stay unchanged.
- R10: A CPU write (`cpu_valid` high, `cpu_del` low) creates the entry, or overwrites it in place if the key already exists. The new entry takes the given port, static and pointer flags and age 0, and is placed as in R7 when it is new. A CPU delete invalidates the matching entry.
- R11: A lookup in the same cycle as a write to the same set returns the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_da | input | MAC_W | Destination MAC to resolve |
| lk_sa | input | MAC_W | Source MAC to refresh or learn |
| lk_vid | input | VID_W | VLAN ID of the frame |
| lk_port | input | PORT_W | Ingress port of the frame |
| eof_valid | input | 1 | End-of-frame status strobe |
| eof_good | input | 1 | Frame had legal length and correct FCS |
| eof_pause | input | 1 | Frame was a pause frame |
| eof_secviol | input | 1 | Frame violated port security |
| port_block | input | NPORTS | Per port: spanning-tree disabled or blocking |
| port_learn_off | input | NPORTS | Per port: learning turned off |
| cpu_valid | input | 1 | Management operation strobe |
| cpu_del | input | 1 | 1 = delete, 0 = write |
| cpu_mac | input | MAC_W | Management key MAC |
| cpu_vid | input | VID_W | Management key VID |
| cpu_port | input | PORT_W | Port or port-map pointer to store |
| cpu_static | input | 1 | Store as static (never aged) |
| cpu_ptr | input | 1 | Port field is a port-map pointer |
| age_tick | input | 1 | Aging period pulse |
| age_dis | input | 1 | Static control: aging disabled |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Destination found |
| res_port | output | PORT_W | Destination port or pointer |
| res_static | output | 1 | Found entry is static |
| res_ptr | output | 1 | Found entry's port field is a pointer |

## Verification
The bench builds the block with IDX_W=2, four ways and NPORTS=4. That gives sixteen entries in four sets, and a full sweep takes four cycles. With this size the bench can search keys arithmetically with its own fold and pick several MACs that land in one set, so a set can be filled, its victim choice forced, and every way made static. The short sweep also lets a full aging lifetime of four ticks, with a refresh in the middle, run in a few hundred cycles.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  // Source of a table write; later sources override earlier ones on an entry.
  typedef enum logic [1:0] {
    WSRC_SWEEP = 2'd0,
    WSRC_REFRESH = 2'd1,
    WSRC_LEARN = 2'd2,
    WSRC_CPU = 2'd3
  } wsrc_e;

  function automatic int way_bits(input int ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction
endpackage

// File: rtl/mlt_way_match.sv
module mlt_way_match #(
  parameter int WAYS = 4,
  parameter int MAC_W = 48,
  parameter int VID_W = 12,
  localparam int WAY_W = mlt_pkg::way_bits(WAYS)
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS*MAC_W-1:0] macs,
  input  logic [WAYS*VID_W-1:0] vids,
  input  logic [MAC_W-1:0]      key_mac,
  input  logic [VID_W-1:0]      key_vid,
  output logic [WAYS-1:0]       match,
  output logic                  hit,
  output logic [WAY_W-1:0]      way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (macs[w*MAC_W +: MAC_W] == key_mac)
                      && (vids[w*VID_W +: VID_W] == key_vid);
  end

  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit = 1'b1;
        way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/mlt_victim.sv
module mlt_victim #(
  parameter int WAYS = 4,
  parameter int AGE_W = 2,
  localparam int WAY_W = mlt_pkg::way_bits(WAYS)
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS-1:0]       stat,
  input  logic [WAYS*AGE_W-1:0] ages,
  output logic [WAY_W-1:0]      way,
  output logic                  ok
);
  logic             free_found;
  logic [WAY_W-1:0] free_way;
  logic             old_found;
  logic [WAY_W-1:0] old_way;
  logic [AGE_W-1:0] old_age;

  always_comb begin
    free_found = 1'b0;
    free_way = '0;
    old_found = 1'b0;
    old_way = '0;
    old_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid[w] && !free_found) begin
        free_found = 1'b1;
        free_way = WAY_W'(w);
      end
      if (valid[w] && !stat[w]
          && (!old_found || (ages[w*AGE_W +: AGE_W] > old_age))) begin
        old_found = 1'b1;
        old_way = WAY_W'(w);
        old_age = ages[w*AGE_W +: AGE_W];
      end
    end
    ok = free_found || old_found;
    way = free_found ? free_way : old_way;
  end
endmodule

// File: rtl/mlt_sweep.sv
module mlt_sweep #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dis,
  output logic             busy,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr <= '0;
    end else if (busy) begin
      if (ptr == LAST) begin
        busy <= 1'b0;
        ptr <= '0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end else if (tick && !dis) begin
      busy <= 1'b1;
      ptr <= '0;
    end
  end
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table #(
  parameter int NPORTS = 26,
  parameter int MAC_W = 48,
  parameter int VID_W = 12,
  parameter int IDX_W = 10,
  parameter int WAYS = 4,
  parameter int AGE_W = 2,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [MAC_W-1:0]  lk_da,
  input  logic [MAC_W-1:0]  lk_sa,
  input  logic [VID_W-1:0]  lk_vid,
  input  logic [PORT_W-1:0] lk_port,
  input  logic              eof_valid,
  input  logic              eof_good,
  input  logic              eof_pause,
  input  logic              eof_secviol,
  input  logic [NPORTS-1:0] port_block,
  input  logic [NPORTS-1:0] port_learn_off,
  input  logic              cpu_valid,
  input  logic              cpu_del,
  input  logic [MAC_W-1:0]  cpu_mac,
  input  logic [VID_W-1:0]  cpu_vid,
  input  logic [PORT_W-1:0] cpu_port,
  input  logic              cpu_static,
  input  logic              cpu_ptr,
  input  logic              age_tick,
  input  logic              age_dis,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PORT_W-1:0] res_port,
  output logic              res_static,
  output logic              res_ptr
);
  import mlt_pkg::*;

  localparam int SETS = 1 << IDX_W;
  localparam int KEY_W = MAC_W + VID_W;
  localparam int WAY_W = way_bits(WAYS);
  localparam int GRP_BIT = MAC_W - 8;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  function automatic logic [IDX_W-1:0] fold_key(input logic [MAC_W-1:0] m,
                                                input logic [VID_W-1:0] v);
    logic [KEY_W-1:0] k;
    k = {v, m};
    fold_key = '0;
    for (int i = 0; i < KEY_W; i++) fold_key[i % IDX_W] ^= k[i];
  endfunction

  // Table storage, one array per field and way.
  logic              t_v   [WAYS][SETS];
  logic              t_st  [WAYS][SETS];
  logic              t_ptr [WAYS][SETS];
  logic [AGE_W-1:0]  t_age [WAYS][SETS];
  logic [MAC_W-1:0]  t_mac [WAYS][SETS];
  logic [VID_W-1:0]  t_vid [WAYS][SETS];
  logic [PORT_W-1:0] t_port[WAYS][SETS];

  // Learning candidate held between lookup and end of frame.
  logic              pend_v;
  logic [MAC_W-1:0]  pend_mac;
  logic [VID_W-1:0]  pend_vid;
  logic [PORT_W-1:0] pend_port;

  logic [IDX_W-1:0] da_idx, sa_idx, pd_idx, cp_idx;
  assign da_idx = fold_key(lk_da, lk_vid);
  assign sa_idx = fold_key(lk_sa, lk_vid);
  assign pd_idx = fold_key(pend_mac, pend_vid);
  assign cp_idx = fold_key(cpu_mac, cpu_vid);

  // Per-set views, packed by way.
  logic [WAYS-1:0]       da_v, sa_v, pd_v, cp_v;
  logic [WAYS*MAC_W-1:0] da_macs, sa_macs, pd_macs, cp_macs;
  logic [WAYS*VID_W-1:0] da_vids, sa_vids, pd_vids, cp_vids;
  logic [WAYS-1:0]       pd_st, cp_st;
  logic [WAYS*AGE_W-1:0] pd_ages, cp_ages;

  for (genvar w = 0; w < WAYS; w++) begin : g_view
    assign da_v[w] = t_v[w][da_idx];
    assign sa_v[w] = t_v[w][sa_idx];
    assign pd_v[w] = t_v[w][pd_idx];
    assign cp_v[w] = t_v[w][cp_idx];
    assign da_macs[w*MAC_W +: MAC_W] = t_mac[w][da_idx];
    assign sa_macs[w*MAC_W +: MAC_W] = t_mac[w][sa_idx];
    assign pd_macs[w*MAC_W +: MAC_W] = t_mac[w][pd_idx];
    assign cp_macs[w*MAC_W +: MAC_W] = t_mac[w][cp_idx];
    assign da_vids[w*VID_W +: VID_W] = t_vid[w][da_idx];
    assign sa_vids[w*VID_W +: VID_W] = t_vid[w][sa_idx];
    assign pd_vids[w*VID_W +: VID_W] = t_vid[w][pd_idx];
    assign cp_vids[w*VID_W +: VID_W] = t_vid[w][cp_idx];
    assign pd_st[w] = t_st[w][pd_idx];
    assign cp_st[w] = t_st[w][cp_idx];
    assign pd_ages[w*AGE_W +: AGE_W] = t_age[w][pd_idx];
    assign cp_ages[w*AGE_W +: AGE_W] = t_age[w][cp_idx];
  end

  // Key searches.
  logic [WAYS-1:0]  da_match, sa_match, pd_match, cp_match;
  logic             da_hit, sa_hit, pd_hit, cp_hit;
  logic [WAY_W-1:0] da_way, sa_way, pd_way, cp_way;

  mlt_way_match #(.WAYS(WAYS), .MAC_W(MAC_W), .VID_W(VID_W)) u_da_match (
    .valid(da_v), .macs(da_macs), .vids(da_vids), .key_mac(lk_da),
    .key_vid(lk_vid), .match(da_match), .hit(da_hit), .way(da_way));
  mlt_way_match #(.WAYS(WAYS), .MAC_W(MAC_W), .VID_W(VID_W)) u_sa_match (
    .valid(sa_v), .macs(sa_macs), .vids(sa_vids), .key_mac(lk_sa),
    .key_vid(lk_vid), .match(sa_match), .hit(sa_hit), .way(sa_way));
  mlt_way_match #(.WAYS(WAYS), .MAC_W(MAC_W), .VID_W(VID_W)) u_pd_match (
    .valid(pd_v), .macs(pd_macs), .vids(pd_vids), .key_mac(pend_mac),
    .key_vid(pend_vid), .match(pd_match), .hit(pd_hit), .way(pd_way));
  mlt_way_match #(.WAYS(WAYS), .MAC_W(MAC_W), .VID_W(VID_W)) u_cp_match (
    .valid(cp_v), .macs(cp_macs), .vids(cp_vids), .key_mac(cpu_mac),
    .key_vid(cpu_vid), .match(cp_match), .hit(cp_hit), .way(cp_way));

  // Placement choices for a new key.
  logic [WAY_W-1:0] pd_vway, cp_vway;
  logic             pd_vok, cp_vok;

  mlt_victim #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pd_victim (
    .valid(pd_v), .stat(pd_st), .ages(pd_ages), .way(pd_vway), .ok(pd_vok));
  mlt_victim #(.WAYS(WAYS), .AGE_W(AGE_W)) u_cp_victim (
    .valid(cp_v), .stat(cp_st), .ages(cp_ages), .way(cp_vway), .ok(cp_vok));

  // Aging sweep controller.
  logic             sweep_busy;
  logic [IDX_W-1:0] sweep_ptr;

  mlt_sweep #(.IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .tick(age_tick), .dis(age_dis),
    .busy(sweep_busy), .ptr(sweep_ptr));

  // Named events.
  logic frame_ok, learn_fire, refresh_fire, cpu_wr_fire, cpu_del_fire;
  logic learn_ok_at_lookup;
  logic [WAY_W-1:0] cpu_wr_way;

  assign frame_ok = eof_good && !eof_pause && !eof_secviol;
  assign learn_fire = eof_valid && pend_v && frame_ok && !pd_hit && pd_vok
                      && !(cpu_valid && (cp_idx == pd_idx));
  assign refresh_fire = lk_valid && sa_hit;
  assign cpu_wr_fire = cpu_valid && !cpu_del && (cp_hit || cp_vok);
  assign cpu_del_fire = cpu_valid && cpu_del && cp_hit;
  assign cpu_wr_way = cp_hit ? cp_way : cp_vway;
  assign learn_ok_at_lookup = !lk_sa[GRP_BIT] && !port_block[lk_port]
                              && !port_learn_off[lk_port];

  // Lookup result register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit <= 1'b0;
      res_port <= '0;
      res_static <= 1'b0;
      res_ptr <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      res_hit <= lk_valid && da_hit;
      res_port <= (lk_valid && da_hit) ? t_port[da_way][da_idx] : '0;
      res_static <= lk_valid && da_hit && t_st[da_way][da_idx];
      res_ptr <= lk_valid && da_hit && t_ptr[da_way][da_idx];
    end
  end

  // Learning candidate.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_mac <= '0;
      pend_vid <= '0;
      pend_port <= '0;
    end else begin
      if (eof_valid) pend_v <= 1'b0;
      if (lk_valid) begin
        pend_v <= !sa_hit && learn_ok_at_lookup;
        pend_mac <= lk_sa;
        pend_vid <= lk_vid;
        pend_port <= lk_port;
      end
    end
  end

  // Table writes, applied in order sweep, refresh, learn, CPU.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) t_v[w][s] <= 1'b0;
    end else begin
      if (sweep_busy) begin
        for (int w = 0; w < WAYS; w++) begin
          if (t_v[w][sweep_ptr] && !t_st[w][sweep_ptr]) begin
            if (t_age[w][sweep_ptr] == AGE_MAX) t_v[w][sweep_ptr] <= 1'b0;
            else t_age[w][sweep_ptr] <= t_age[w][sweep_ptr] + 1'b1;
          end
        end
      end
      if (refresh_fire) t_age[sa_way][sa_idx] <= '0;
      if (learn_fire) begin
        t_v[pd_vway][pd_idx] <= 1'b1;
        t_st[pd_vway][pd_idx] <= 1'b0;
        t_ptr[pd_vway][pd_idx] <= 1'b0;
        t_age[pd_vway][pd_idx] <= '0;
        t_mac[pd_vway][pd_idx] <= pend_mac;
        t_vid[pd_vway][pd_idx] <= pend_vid;
        t_port[pd_vway][pd_idx] <= pend_port;
      end
      if (cpu_wr_fire) begin
        t_v[cpu_wr_way][cp_idx] <= 1'b1;
        t_st[cpu_wr_way][cp_idx] <= cpu_static;
        t_ptr[cpu_wr_way][cp_idx] <= cpu_ptr;
        t_age[cpu_wr_way][cp_idx] <= '0;
        t_mac[cpu_wr_way][cp_idx] <= cpu_mac;
        t_vid[cpu_wr_way][cp_idx] <= cpu_vid;
        t_port[cpu_wr_way][cp_idx] <= cpu_port;
      end
      if (cpu_del_fire) t_v[cp_way][cp_idx] <= 1'b0;
    end
  end

  logic unused_ok;
  assign unused_ok = ^{pd_match, cp_match, pd_way, WSRC_CPU};
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
  parameter int WAYS = 4,
  parameter int PORT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              age_dis,
  input logic              res_valid,
  input logic              res_hit,
  input logic [PORT_W-1:0] res_port,
  input logic              res_static,
  input logic              res_ptr,
  input logic [WAYS-1:0]   da_match,
  input logic [WAYS-1:0]   sa_match,
  input logic              sweep_busy
);
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r2_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  a_r2_miss_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_port == '0 && !res_static && !res_ptr));
  a_r2_hit_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);
  // R3 and R10: a key is stored in at most one way of its set.
  a_r3_unique_da_key: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(da_match));
  a_r3_unique_sa_key: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sa_match));
  a_r9_no_sweep_start: assert property (@(posedge clk) disable iff (!rst_n)
    (age_dis && !sweep_busy) |=> !sweep_busy);
endmodule

bind mac_learn_table mlt_checker #(.WAYS(WAYS), .PORT_W(PORT_W)) u_mlt_checker (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .age_dis(age_dis),
  .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port),
  .res_static(res_static), .res_ptr(res_ptr), .da_match(da_match),
  .sa_match(sa_match), .sweep_busy(sweep_busy));

// File: tb/sim_mac_learn_table.sv
`timescale 1ns/1ps
module sim_mac_learn_table;
  localparam int NP = 4;
  localparam int PW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic lk_valid, eof_valid, eof_good, eof_pause, eof_secviol;
  logic [47:0] lk_da, lk_sa, cpu_mac;
  logic [11:0] lk_vid, cpu_vid;
  logic [PW-1:0] lk_port, cpu_port, res_port;
  logic [NP-1:0] port_block, port_learn_off;
  logic cpu_valid, cpu_del, cpu_static, cpu_ptr, age_tick, age_dis;
  logic res_valid, res_hit, res_static, res_ptr;

  mac_learn_table #(.NPORTS(NP), .IDX_W(IW), .WAYS(4), .AGE_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_da(lk_da), .lk_sa(lk_sa),
    .lk_vid(lk_vid), .lk_port(lk_port), .eof_valid(eof_valid), .eof_good(eof_good),
    .eof_pause(eof_pause), .eof_secviol(eof_secviol), .port_block(port_block),
    .port_learn_off(port_learn_off), .cpu_valid(cpu_valid), .cpu_del(cpu_del),
    .cpu_mac(cpu_mac), .cpu_vid(cpu_vid), .cpu_port(cpu_port),
    .cpu_static(cpu_static), .cpu_ptr(cpu_ptr), .age_tick(age_tick),
    .age_dis(age_dis), .res_valid(res_valid), .res_hit(res_hit),
    .res_port(res_port), .res_static(res_static), .res_ptr(res_ptr));

  int checks = 0;
  int fails = 0;
  localparam logic [47:0] GRP_SA = 48'h01_00_5e_00_00_01;
  localparam logic [47:0] BASE = 48'h02_00_00_00_00_00;

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Bench index: fold the key in IW-bit slices.
  function automatic int bidx(input logic [47:0] m, input logic [11:0] v);
    logic [59:0] k;
    int r;
    k = {v, m};
    r = 0;
    for (int c = 0; c < 60 / IW; c++) r = r ^ int'(k[c*IW +: IW]);
    return r;
  endfunction

  function automatic logic [47:0] nth_in_set(input int set, input logic [11:0] v,
                                             input int n);
    int cnt;
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      if (bidx(BASE + 48'(i), v) == set) begin
        if (cnt == n) return BASE + 48'(i);
        cnt++;
      end
    end
    return BASE;
  endfunction

  task automatic idle();
    lk_valid = 0; eof_valid = 0; cpu_valid = 0; age_tick = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    eof_good = 0; eof_pause = 0; eof_secviol = 0; cpu_del = 0;
    cpu_static = 0; cpu_ptr = 0; age_dis = 0;
    port_block = '0; port_learn_off = '0;
    lk_da = '0; lk_sa = '0; lk_vid = '0; lk_port = '0;
    cpu_mac = '0; cpu_vid = '0; cpu_port = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic lookup(input logic [47:0] da, input logic [11:0] v,
                        output int hit, output int port, output int st,
                        output int ptr);
    lk_valid = 1; lk_da = da; lk_sa = GRP_SA; lk_vid = v; lk_port = 0;
    @(negedge clk);
    lk_valid = 0;
    hit = res_hit; port = res_port; st = res_static; ptr = res_ptr;
  endtask

  task automatic frame(input logic [47:0] sa, input logic [11:0] v,
                       input int port, input bit good, input bit pause,
                       input bit sec);
    lk_valid = 1; lk_sa = sa; lk_da = GRP_SA; lk_vid = v; lk_port = PW'(port);
    @(negedge clk);
    lk_valid = 0;
    eof_valid = 1; eof_good = good; eof_pause = pause; eof_secviol = sec;
    @(negedge clk);
    eof_valid = 0;
  endtask

  task automatic cpu_op(input bit del, input logic [47:0] m, input logic [11:0] v,
                        input int port, input bit st, input bit ptr);
    cpu_valid = 1; cpu_del = del; cpu_mac = m; cpu_vid = v;
    cpu_port = PW'(port); cpu_static = st; cpu_ptr = ptr;
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic tick();
    age_tick = 1;
    @(negedge clk);
    age_tick = 0;
    repeat (8) @(negedge clk);
  endtask

  int h, p, s, q;
  logic [47:0] m [5];

  initial begin
    idle();
    do_reset();

    // R1: empty after reset
    chk("R1 res_valid after reset", res_valid, 0);
    for (int i = 0; i < 4; i++) begin
      lookup(nth_in_set(i, 12'd0, 0), 12'd0, h, p, s, q);
      chk("R1 empty lookup misses", h, 0);
    end

    // R2 / R5: clean learn then hit
    m[0] = nth_in_set(1, 12'd5, 0);
    frame(m[0], 12'd5, 1, 1, 0, 0);
    lookup(m[0], 12'd5, h, p, s, q);
    chk("R2 learned hit", h, 1);
    chk("R2 learned port", p, 1);
    chk("R5 learned is dynamic", s, 0);
    chk("R5 learned has no ptr", q, 0);
    chk("R2 res_valid one cycle", res_valid, 1);
    @(negedge clk);
    chk("R2 res_valid drops", res_valid, 0);

    // R5: bad frames not learned
    m[1] = BASE + 48'h100;
    frame(m[1], 12'd5, 2, 0, 0, 0);
    lookup(m[1], 12'd5, h, p, s, q);
    chk("R5 error frame not learned", h, 0);
    frame(m[1], 12'd5, 2, 1, 1, 0);
    lookup(m[1], 12'd5, h, p, s, q);
    chk("R5 pause frame not learned", h, 0);
    frame(m[1], 12'd5, 2, 1, 0, 1);
    lookup(m[1], 12'd5, h, p, s, q);
    chk("R5 security frame not learned", h, 0);

    // R6: group source, blocked port, learning off
    frame(48'h03_00_00_00_00_07, 12'd5, 1, 1, 0, 0);
    lookup(48'h03_00_00_00_00_07, 12'd5, h, p, s, q);
    chk("R6 group SA not learned", h, 0);
    port_block[2] = 1;
    frame(m[1], 12'd5, 2, 1, 0, 0);
    port_block[2] = 0;
    lookup(m[1], 12'd5, h, p, s, q);
    chk("R6 blocked port not learned", h, 0);
    port_learn_off[3] = 1;
    frame(m[1], 12'd5, 3, 1, 0, 0);
    port_learn_off[3] = 0;
    lookup(m[1], 12'd5, h, p, s, q);
    chk("R6 learning off not learned", h, 0);
    frame(m[1], 12'd5, 3, 1, 0, 0);
    lookup(m[1], 12'd5, h, p, s, q);
    chk("R6 open port learns", p * 10 + h, 31);

    // R3: same MAC under two VIDs
    do_reset();
    m[2] = BASE + 48'h42;
    frame(m[2], 12'd1, 1, 1, 0, 0);
    frame(m[2], 12'd2, 2, 1, 0, 0);
    lookup(m[2], 12'd1, h, p, s, q);
    chk("R3 vid1 port", h * 10 + p, 11);
    lookup(m[2], 12'd2, h, p, s, q);
    chk("R3 vid2 port", h * 10 + p, 12);
    lookup(m[2], 12'd3, h, p, s, q);
    chk("R3 vid3 miss", h, 0);

    // R10: CPU write and delete
    cpu_op(0, m[2], 12'd7, 3, 1, 1);
    lookup(m[2], 12'd7, h, p, s, q);
    chk("R10 cpu write fields", h * 1000 + p * 100 + s * 10 + q, 1311);
    cpu_op(0, m[2], 12'd1, 2, 0, 0);
    lookup(m[2], 12'd1, h, p, s, q);
    chk("R10 cpu overwrite port", h * 10 + p, 12);
    cpu_op(1, m[2], 12'd1, 0, 0, 0);
    lookup(m[2], 12'd1, h, p, s, q);
    chk("R10 cpu delete", h, 0);
    lookup(m[2], 12'd2, h, p, s, q);
    chk("R10 delete keeps other vid", h, 1);

    // R4 / R8: refresh and expiry
    do_reset();
    m[0] = BASE + 48'h11;
    m[1] = BASE + 48'h22;
    frame(m[0], 12'd0, 1, 1, 0, 0);
    frame(m[1], 12'd0, 2, 1, 0, 0);
    tick(); tick();
    frame(m[0], 12'd0, 1, 1, 0, 0);
    tick(); tick();
    lookup(m[1], 12'd0, h, p, s, q);
    chk("R8 expired after 4 sweeps", h, 0);
    lookup(m[0], 12'd0, h, p, s, q);
    chk("R4 refreshed entry kept", h, 1);
    tick();
    lookup(m[0], 12'd0, h, p, s, q);
    chk("R8 age 3 survives", h, 1);
    tick();
    lookup(m[0], 12'd0, h, p, s, q);
    chk("R8 overflow removes", h, 0);

    // R9: aging disabled
    do_reset();
    age_dis = 1;
    frame(m[0], 12'd0, 1, 1, 0, 0);
    for (int i = 0; i < 5; i++) tick();
    lookup(m[0], 12'd0, h, p, s, q);
    chk("R9 aging disabled keeps entry", h, 1);
    age_dis = 0;

    // R7: victim choice in a full set
    do_reset();
    for (int i = 0; i < 5; i++) m[i] = nth_in_set(0, 12'd0, i);
    for (int i = 0; i < 4; i++) frame(m[i], 12'd0, i, 1, 0, 0);
    tick();
    cpu_op(0, m[0], 12'd0, 0, 1, 0);
    frame(m[2], 12'd0, 2, 1, 0, 0);
    frame(m[4], 12'd0, 3, 1, 0, 0);
    lookup(m[1], 12'd0, h, p, s, q);
    chk("R7 oldest lowest way replaced", h, 0);
    lookup(m[4], 12'd0, h, p, s, q);
    chk("R7 new entry placed", h * 10 + p, 13);
    lookup(m[3], 12'd0, h, p, s, q);
    chk("R7 tie loser kept", h, 1);
    lookup(m[2], 12'd0, h, p, s, q);
    chk("R7 refreshed kept", h, 1);
    lookup(m[0], 12'd0, h, p, s, q);
    chk("R7 static kept", h, 1);

    // R7 / R8: all-static set
    do_reset();
    for (int i = 0; i < 5; i++) m[i] = nth_in_set(1, 12'd0, i);
    for (int i = 0; i < 4; i++) cpu_op(0, m[i], 12'd0, i, 1, 0);
    frame(m[4], 12'd0, 1, 1, 0, 0);
    lookup(m[4], 12'd0, h, p, s, q);
    chk("R7 all static no write", h, 0);
    for (int i = 0; i < 5; i++) tick();
    for (int i = 0; i < 4; i++) begin
      lookup(m[i], 12'd0, h, p, s, q);
      chk("R8 static never aged", h * 10 + p, 10 + i);
    end

    // R11: lookup in the same cycle as the learn write
    do_reset();
    m[0] = BASE + 48'h77;
    lk_valid = 1; lk_sa = m[0]; lk_da = GRP_SA; lk_vid = 12'd9; lk_port = 2;
    @(negedge clk);
    lk_da = m[0]; lk_sa = GRP_SA;
    eof_valid = 1; eof_good = 1; eof_pause = 0; eof_secviol = 0;
    @(negedge clk);
    lk_valid = 0; eof_valid = 0;
    chk("R11 same-cycle lookup sees old state", res_hit, 0);
    lookup(m[0], 12'd9, h, p, s, q);
    chk("R11 next lookup hits", h * 10 + p, 12);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule